// File: doc/BRIEF.md
# Video Luma/Chroma Adjustment Stage

This block is a two-stage pixel pipeline for 4:2:2 component video. On each accepted beat it takes one 8-bit luma sample and one 8-bit multiplexed colour-difference sample (Cb or Cr, both coded offset-binary around 128). It applies three picture controls to the beat:

- a contrast gain to luma, taken about mid-grey;
- a brightness offset to luma;
- a saturation gain to the colour-difference sample.

Results are rounded and clipped back to 8 bits.

The two gains are signed fixed-point codes with six fractional bits, so 0x40 is unity. Negative codes invert luma or chroma about its midpoint. The three controls sit in registers written through a one-cycle write port. A write never changes a pixel already accepted: the new value applies from the first pixel accepted after the write.

Top module: `luma_chroma_adjust`

## Requirements
- R1: After reset, brightness is 0x80, contrast is 0x40 and saturation is 0x40. While reset is held, out_valid, out_y and out_c are 0.
- R2: A write with cfg_we high stores cfg_wdata into one control:
  - address 0 selects brightness;
  - address 1 selects contrast;
  - address 2 selects saturation;
  - a write to address 3 changes nothing seen at the outputs.
- R3: A beat accepted on clock edge k appears on the outputs after edge k+1, with out_valid high for exactly that cycle. A cycle with in_valid low gives a cycle with out_valid low two edges later. There is no backpressure.
- R4: Luma output is clip(floor(((Y-128)*G + 32)/64) + B). G is the contrast code read as two's complement and B is the brightness code read as unsigned. With G=0x40 and B=0x80, the output equals the input.
- R5: Any luma or chroma result below 0 becomes 0, and any result above 255 becomes 255.
- R6: Contrast code 0x00 makes every luma output equal to the brightness code. Codes 0xC0 (gain -1) and 0x80 (gain -2) invert luma about 128.
- R7: Chroma output is clip(floor(((C-128)*S + 32)/64) + 128). S is the saturation code read as two's complement, so 0xC0 and 0x80 invert chroma.
- R8: Saturation code 0x00 makes every chroma output 128.
- R9: A pixel accepted in the same cycle as a control write uses the old value of that control. The next accepted pixel uses the new value.
- R10: Rounding adds half an LSB (32) before the arithmetic shift. A product whose low six bits equal exactly 32 therefore rounds toward positive infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 2 | Control select: 0 brightness, 1 contrast, 2 saturation |
| cfg_wdata | input | W | Control write data |
| in_valid | input | 1 | Input beat valid |
| in_y | input | W | Luma sample, unsigned |
| in_c | input | W | Cb or Cr sample, offset-binary |
| out_valid | output | 1 | Output beat valid |
| out_y | output | W | Adjusted luma |
| out_c | output | W | Adjusted Cb or Cr |

## Verification
The bench builds the block at its default width of 8 bits with 6 fractional gain bits. At that size every one of the 256 luma and chroma codes can be streamed through each setting.

The sweep covers eight gain codes, including zero, unity, the 0x47 nominal, full scale and the two inverting codes, crossed with four brightness levels. This reaches both clip rails, exact half-LSB ties and the inverted ranges, all at full streaming rate with periodic idle gaps. Directed beats then write a control in the same cycle as a pixel and write to the unused address.

// File: rtl/luma_chroma_adjust.sv
`timescale 1ns/1ps
module luma_chroma_adjust #(
  parameter int W    = 8,
  parameter int FRAC = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         in_valid,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_c,
  output logic         out_valid,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_c
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] MID   = W'(1 << (W - 1));
  localparam logic [W-1:0] UNITY = W'(1 << FRAC);
  localparam logic signed [PW-1:0] HALF = PW'(1 << (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((1 << W) - 1);
  localparam logic signed [PW-1:0] MIDP = PW'(1 << (W - 1));

  logic [W-1:0] bri_r, con_r, sat_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bri_r <= MID;
      con_r <= UNITY;
      sat_r <= UNITY;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    bri_r <= cfg_wdata;
        2'd1:    con_r <= cfg_wdata;
        2'd2:    sat_r <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic signed [W-1:0] dy, dc;
  assign dy = $signed({~in_y[W-1], in_y[W-2:0]});
  assign dc = $signed({~in_c[W-1], in_c[W-2:0]});

  logic                 v1;
  logic signed [PW-1:0] py_q, pc_q;
  logic [W-1:0]         bri_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      py_q  <= '0;
      pc_q  <= '0;
      bri_q <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        py_q  <= dy * $signed(con_r);
        pc_q  <= dc * $signed(sat_r);
        bri_q <= bri_r;
      end
    end
  end

  logic signed [PW-1:0] ry, rc, sy, sc;
  assign ry = (py_q + HALF) >>> FRAC;
  assign rc = (pc_q + HALF) >>> FRAC;
  assign sy = ry + $signed({{(PW-W){1'b0}}, bri_q});
  assign sc = rc + MIDP;

  function automatic logic [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v[PW-1]) return '0;
    if (v > MAXV) return MAXV[W-1:0];
    return v[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_y <= clip(sy);
        out_c <= clip(sc);
      end
    end
  end

  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R3
  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R3
  AST_UNITY_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(con_r, 2) == UNITY && $past(bri_r, 2) == MID)
      |-> out_y == $past(in_y, 2)); // R4
  AST_BLANK_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(con_r, 2) == '0) |-> out_y == $past(bri_r, 2)); // R6
  AST_COLOUR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sat_r, 2) == '0) |-> out_c == MID); // R8
endmodule

// File: tb/tb_luma_chroma_adjust.sv
`timescale 1ns/1ps
module tb_luma_chroma_adjust;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic in_valid = 0;
  logic [7:0] in_y = 0, in_c = 0;
  logic out_valid;
  logic [7:0] out_y, out_c;

  always #2 clk = ~clk;

  luma_chroma_adjust #(.W(8), .FRAC(6)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_y(in_y), .in_c(in_c),
    .out_valid(out_valid), .out_y(out_y), .out_c(out_c));

  int n_chk = 0, n_fail = 0;
  int m_bri = 128, m_con = 64, m_sat = 64;
  int qy[$], qc[$];
  string qty[$], qtc[$];
  string tag_force = "";
  bit mon_on = 0, prev_v = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sg(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int clip(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  task automatic beat(bit v, int y, int c, bit we, int a, int d);
    @(negedge clk);
    in_valid = v; in_y = 8'(y); in_c = 8'(c);
    cfg_we = we; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    if (v) begin
      int p, u, pc;
      string t;
      p = (y - 128) * sg(m_con);
      u = ((p + 32) >>> 6) + m_bri;
      pc = (c - 128) * sg(m_sat);
      if (m_con == 0 || m_con >= 128) t = "R6";
      else if (u < 0 || u > 255) t = "R5";
      else if ((p & 63) == 32) t = "R10";
      else t = "R4";
      if (tag_force != "") t = tag_force;
      qy.push_back(clip(u)); qty.push_back(t);
      qc.push_back(clip(((pc + 32) >>> 6) + 128));
      t = (m_sat == 0) ? "R8" : "R7";
      if (tag_force != "") t = tag_force;
      qtc.push_back(t);
    end
    if (we) begin
      if (a == 0) m_bri = d;
      else if (a == 1) m_con = d;
      else if (a == 2) m_sat = d;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      check("R3 valid", int'(out_valid), int'(prev_v));
      if (out_valid && qy.size() > 0) begin
        check(qty.pop_front(), int'(out_y), qy.pop_front());
        check(qtc.pop_front(), int'(out_c), qc.pop_front());
      end
    end
    prev_v = in_valid;
  end

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int gains[8] = '{8'h00, 8'h40, 8'h47, 8'h7F, 8'hC0, 8'h80, 8'h20, 8'hE1};
    int bris[4]  = '{8'h80, 8'h00, 8'hFF, 8'h95};
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_y in reset", int'(out_y), 0);
    check("R1 out_c in reset", int'(out_c), 0);
    @(negedge clk); rst_n = 1;
    mon_on = 1;
    tag_force = "R1";
    beat(1, 37, 200, 0, 0, 0);
    beat(1, 250, 3, 0, 0, 0);
    tag_force = "";
    beat(0, 0, 0, 0, 0, 0);
    for (int g = 0; g < 8; g++) begin
      for (int b = 0; b < 4; b++) begin
        beat(0, 0, 0, 1, 1, gains[g]);
        beat(0, 0, 0, 1, 2, gains[(g + b) % 8]);
        beat(0, 0, 0, 1, 0, bris[b]);
        for (int i = 0; i < 256; i++) begin
          beat(1, i, i ^ 8'h5A, 0, 0, 0);
          if (i % 17 == 0) beat(0, 0, 0, 0, 0, 0);
        end
      end
    end
    beat(0, 0, 0, 1, 0, 128);
    beat(0, 0, 0, 1, 1, 64);
    beat(0, 0, 0, 1, 2, 64);
    tag_force = "R9";
    beat(1, 200, 180, 1, 1, 0);
    beat(1, 200, 180, 1, 2, 0);
    beat(1, 90, 60, 0, 0, 0);
    tag_force = "R2";
    beat(1, 77, 99, 1, 3, 0);
    beat(1, 77, 99, 0, 0, 0);
    beat(1, 77, 99, 1, 0, 20);
    beat(1, 77, 99, 0, 0, 0);
    tag_force = "";
    repeat (4) beat(0, 0, 0, 0, 0, 0);
    check("R3 drained", qy.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule